// File: doc/BRIEF.md
# Audio Frame Sequencer with Frame Interrupt

This block divides a CPU-cycle enable into the timing of an audio frame. Each frame is a series of steps. On each step the block sends out a one-cycle quarter-frame tick, and on some steps also a half-frame tick. The audio channels use these ticks for their envelope and length timing. The sequencer runs in one of two modes. The four-step mode raises a level interrupt once per sequence. The five-step mode is longer and never interrupts. The frame runs on its own clock of CPU cycles, not on the video timing, and each frame lasts a little longer than one 60 Hz video frame.

Software writes a two-bit control field. One bit selects the mode and the other masks the interrupt. Every write starts the step sequence again from zero. A read of the status register sends a one-cycle strobe, and that strobe acknowledges a pending interrupt. The status logic reports the interrupt flag as bit 6 of the status byte. The interrupt line stays high until software clears the flag.

Top module: `frame_seq_top`

## Requirements
- R1: After a synchronous reset, `quarter_tick`, `half_tick`, `frame_flag` and `irq` are all 0. The block is then in four-step mode, the interrupt is unmasked and the step count is 0.
- R2: Four-step mode has steps at counts STEP1, STEP2, STEP3 and STEP4 (defaults 7457, 14913, 22371, 29829). A step is an enabled cycle whose count equals the step value. Each step gives a one-cycle `quarter_tick` in the cycle after it. `half_tick` also pulses with the ticks of steps 2 and 4.
- R3: After the final step the count returns to 0. A four-step sequence lasts STEP4+1 enabled cycles and a five-step sequence lasts STEP5+1.
- R4: In four-step mode, with the interrupt unmasked, step 4 sets `frame_flag` in the same cycle as its tick. `irq` is active high and equals `frame_flag`. It stays high with no further input until something clears it.
- R5: When `ctrl_bits[1]` is written as 1 (register bit 7), the block enters five-step mode. In this mode `quarter_tick` pulses for steps 1, 2, 3 and 5, with step 5 at STEP5 (default 37281). `half_tick` pulses for steps 2 and 5. Step 4 gives no tick, and `frame_flag` is never set.
- R6: A write with `ctrl_bits[0]` = 1 (register bit 6) masks the interrupt. The same write clears a pending flag in the next cycle, and no flag is set while the mask holds. A write with `ctrl_bits[0]` = 0 leaves a pending flag unchanged.
- R7: A `stat_rd` strobe clears `frame_flag` from the next cycle on. If the strobe comes in the same cycle that the flag is set, the set wins and the flag stays 1.
- R8: Any control write sets the count to 0, even if `cyc_en` is high in the same cycle. The first step after the write falls on the (STEP1+1)-th enabled cycle after it.
- R9: A write that selects five-step mode pulses both `quarter_tick` and `half_tick` in the next cycle.
- R10: While `cyc_en` is 0 and no write occurs, the count holds and no tick is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_en | input | 1 | CPU-cycle enable; each high cycle advances the count |
| ctrl_wr | input | 1 | Write strobe for the frame-control field |
| ctrl_bits | input | 2 | [1] five-step mode, [0] interrupt mask |
| stat_rd | input | 1 | Status-register read strobe (acknowledge) |
| quarter_tick | output | 1 | One-cycle quarter-frame tick |
| half_tick | output | 1 | One-cycle half-frame tick |
| frame_flag | output | 1 | Frame interrupt flag, shown as status bit 6 |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The hardest case to reach from the ports is a status read that falls in exactly the same cycle as the step-4 flag set. To get there, the bench first writes the control field, which starts the count at a known cycle. With the enable held high, it then counts STEP4 cycles and places the read strobe on the next one. The bench also uses small step values and an enable that fires only on some cycles. It checks that a masked write clears a pending flag while an unmasked write leaves it set.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  typedef enum logic {
    MODE_FOUR = 1'b0,
    MODE_FIVE = 1'b1
  } seq_mode_e;

  typedef struct packed {
    logic quarter;
    logic half;
  } tick_s;

  localparam int unsigned NSTEP = 5;

endpackage

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_i,
  input  logic [1:0] bits_i,
  output seq_mode_e mode_o,
  output logic      inhibit_o,
  output logic      wr_five_o,
  output logic      wr_inhibit_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o    <= MODE_FOUR;
      inhibit_o <= 1'b0;
    end else if (wr_i) begin
      mode_o    <= seq_mode_e'(bits_i[1]);
      inhibit_o <= bits_i[0];
    end
  end

  assign wr_five_o    = wr_i && bits_i[1];
  assign wr_inhibit_o = wr_i && bits_i[0];

endmodule

// File: rtl/frame_seq_counter.sv
module frame_seq_counter
  import frame_seq_pkg::*;
#(
  parameter int unsigned STEP1 = 7457,
  parameter int unsigned STEP2 = 14913,
  parameter int unsigned STEP3 = 22371,
  parameter int unsigned STEP4 = 29829,
  parameter int unsigned STEP5 = 37281,
  parameter int unsigned CW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             restart,
  input  logic             five_step,
  output logic [CW-1:0]    cnt_o,
  output logic [NSTEP-1:0] hit_o
);

  localparam logic [CW-1:0] STEP_AT [NSTEP] =
    '{CW'(STEP1), CW'(STEP2), CW'(STEP3), CW'(STEP4), CW'(STEP5)};

  logic wrap;

  for (genvar i = 0; i < NSTEP; i++) begin : g_hit
    if (i == NSTEP - 1) begin : g_last
      assign hit_o[i] = cyc_en && !restart && five_step && (cnt_o == STEP_AT[i]);
    end else begin : g_mid
      assign hit_o[i] = cyc_en && !restart && (cnt_o == STEP_AT[i]);
    end
  end

  assign wrap = five_step ? hit_o[NSTEP-1] : hit_o[NSTEP-2];

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_o <= '0;
    end else if (cyc_en) begin
      cnt_o <= wrap ? '0 : cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/frame_seq_irq.sv
module frame_seq_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
    end else if (set_i) begin
      flag_o <= 1'b1;
    end else if (clr_i) begin
      flag_o <= 1'b0;
    end
  end

endmodule

// File: rtl/frame_seq_top.sv
module frame_seq_top
  import frame_seq_pkg::*;
#(
  parameter int unsigned STEP1 = 7457,
  parameter int unsigned STEP2 = 14913,
  parameter int unsigned STEP3 = 22371,
  parameter int unsigned STEP4 = 29829,
  parameter int unsigned STEP5 = 37281
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cyc_en,
  input  logic       ctrl_wr,
  input  logic [1:0] ctrl_bits,
  input  logic       stat_rd,
  output logic       quarter_tick,
  output logic       half_tick,
  output logic       frame_flag,
  output logic       irq
);

  localparam int unsigned CW = $clog2(STEP5 + 1);

  seq_mode_e        mode;
  logic             five_step;
  logic             inhibit_q;
  logic             wr_five;
  logic             wr_inhibit;
  logic [CW-1:0]    cnt;
  logic [NSTEP-1:0] hit;
  logic             step4_full;
  logic             flag_set;
  logic             flag_clr;
  tick_s            tick_d;
  tick_s            tick_q;

  frame_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .wr_i         (ctrl_wr),
    .bits_i       (ctrl_bits),
    .mode_o       (mode),
    .inhibit_o    (inhibit_q),
    .wr_five_o    (wr_five),
    .wr_inhibit_o (wr_inhibit)
  );

  assign five_step = (mode == MODE_FIVE);

  frame_seq_counter #(
    .STEP1 (STEP1),
    .STEP2 (STEP2),
    .STEP3 (STEP3),
    .STEP4 (STEP4),
    .STEP5 (STEP5),
    .CW    (CW)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .cyc_en    (cyc_en),
    .restart   (ctrl_wr),
    .five_step (five_step),
    .cnt_o     (cnt),
    .hit_o     (hit)
  );

  assign step4_full = hit[3] && !five_step;

  always_comb begin
    tick_d.quarter = hit[0] || hit[1] || hit[2] || step4_full || hit[4] || wr_five;
    tick_d.half    = hit[1] || step4_full || hit[4] || wr_five;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
    end else begin
      tick_q <= tick_d;
    end
  end

  assign flag_set = step4_full && !inhibit_q;
  assign flag_clr = stat_rd || wr_inhibit;

  frame_seq_irq u_irq (
    .clk    (clk),
    .rst    (rst),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (frame_flag)
  );

  assign quarter_tick = tick_q.quarter;
  assign half_tick    = tick_q.half;
  assign irq          = frame_flag;

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int unsigned STEP4 = 29829,
  parameter int unsigned STEP5 = 37281,
  parameter int unsigned CW    = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cyc_en,
  input logic          ctrl_wr,
  input logic [1:0]    ctrl_bits,
  input logic          stat_rd,
  input logic          quarter_tick,
  input logic          half_tick,
  input logic          frame_flag,
  input logic [CW-1:0] cnt,
  input logic          five,
  input logic          inhibit
);

  p_flag_source_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_flag) |-> (!$past(five) && !$past(inhibit)));

  p_no_flag_five_r5: assert property (@(posedge clk) disable iff (rst)
    (five && !ctrl_wr) |=> !$rose(frame_flag));

  p_mask_clears_r6: assert property (@(posedge clk) disable iff (rst)
    inhibit |-> !frame_flag);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && cnt != CW'(STEP4)) |=> !frame_flag);

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (cnt == '0));

  p_five_write_ticks_r9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_bits[1]) |=> (quarter_tick && half_tick));

  p_half_with_quarter_r2: assert property (@(posedge clk) disable iff (rst)
    half_tick |-> quarter_tick);

  p_count_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= (five ? CW'(STEP5) : CW'(STEP4)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!cyc_en && !ctrl_wr) |=> ($stable(cnt) && !quarter_tick));

endmodule

bind frame_seq_top frame_seq_chk #(
  .STEP4 (STEP4),
  .STEP5 (STEP5),
  .CW    (CW)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cyc_en       (cyc_en),
  .ctrl_wr      (ctrl_wr),
  .ctrl_bits    (ctrl_bits),
  .stat_rd      (stat_rd),
  .quarter_tick (quarter_tick),
  .half_tick    (half_tick),
  .frame_flag   (frame_flag),
  .cnt          (cnt),
  .five         (five_step),
  .inhibit      (inhibit_q)
);

// File: tb/frame_seq_top_tb_top.sv
`timescale 1ns/1ps
module frame_seq_top_tb_top;

  localparam int S1 = 11;
  localparam int S2 = 23;
  localparam int S3 = 34;
  localparam int S4 = 46;
  localparam int S5 = 58;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [1:0] ctrl_bits = 2'b00;
  logic       stat_rd = 1'b0;
  logic       quarter_tick, half_tick, frame_flag, irq;

  int checks = 0;
  int fails  = 0;
  int en_mode = 0;
  int en_phase = 0;

  // reference model state
  int m_cnt = 0;
  bit m_five = 0, m_inh = 0, m_flag = 0, m_q = 0, m_h = 0;

  always #5 clk = ~clk;

  frame_seq_top #(
    .STEP1(S1), .STEP2(S2), .STEP3(S3), .STEP4(S4), .STEP5(S5)
  ) dut_i (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .ctrl_wr(ctrl_wr),
    .ctrl_bits(ctrl_bits), .stat_rd(stat_rd),
    .quarter_tick(quarter_tick), .half_tick(half_tick),
    .frame_flag(frame_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // enable pattern generator: 0 always, 1 every third cycle, 2 never
  always @(negedge clk) begin
    en_phase = (en_phase + 1) % 3;
    case (en_mode)
      0: cyc_en = 1'b1;
      1: cyc_en = (en_phase == 0);
      default: cyc_en = 1'b0;
    endcase
  end

  // behavioural reference, updated on every edge
  always @(posedge clk) begin
    bit set, clr, nq, nh;
    if (rst) begin
      m_cnt = 0; m_five = 0; m_inh = 0; m_flag = 0; m_q = 0; m_h = 0;
    end else begin
      set = 0; nq = 0; nh = 0;
      clr = stat_rd || (ctrl_wr && ctrl_bits[0]);
      if (ctrl_wr) begin
        if (ctrl_bits[1]) begin nq = 1; nh = 1; end
        m_five = ctrl_bits[1];
        m_inh  = ctrl_bits[0];
        m_cnt  = 0;
      end else if (cyc_en) begin
        if (m_cnt == S1 || m_cnt == S3) nq = 1;
        if (m_cnt == S2) begin nq = 1; nh = 1; end
        if (!m_five && m_cnt == S4) begin
          nq = 1; nh = 1; set = !m_inh; m_cnt = 0;
        end else if (m_five && m_cnt == S5) begin
          nq = 1; nh = 1; m_cnt = 0;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
      if (set) m_flag = 1;
      else if (clr) m_flag = 0;
      m_q = nq; m_h = nh;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(quarter_tick == m_q, "R2 quarter vs model", quarter_tick, m_q);
      chk(half_tick == m_h,    "R2 half vs model",    half_tick,    m_h);
      chk(frame_flag == m_flag, "R4 flag vs model",   frame_flag,   m_flag);
      chk(irq == m_flag,        "R4 irq vs model",    irq,          m_flag);
    end
  end

  task automatic write_ctrl(input logic [1:0] b);
    ctrl_wr = 1'b1; ctrl_bits = b;
    @(negedge clk);
    ctrl_wr = 1'b0; ctrl_bits = 2'b00;
  endtask

  task automatic read_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int n;
    int hcnt;
    int htimes [4];
    int flag_seen;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(quarter_tick == 0 && half_tick == 0, "R1 ticks after reset", quarter_tick, 0);
    chk(frame_flag == 0 && irq == 0, "R1 flag after reset", frame_flag, 0);

    // R4 four-step flag set, irq held
    write_ctrl(2'b00);
    repeat (S4 + 1) @(negedge clk);
    chk(frame_flag == 1, "R4 flag at step 4", frame_flag, 1);
    repeat (20) @(negedge clk);
    chk(irq == 1, "R4 irq held without ack", irq, 1);
    // R7 read clears
    read_stat();
    chk(frame_flag == 0, "R7 read clears flag", frame_flag, 0);

    // R8 restart timing
    write_ctrl(2'b00);
    n = 0;
    do begin @(negedge clk); n++; end while (!quarter_tick && n < 1000);
    chk(n == S1 + 1, "R8 first step after write", n, S1 + 1);

    // R7 coincident read: set wins
    write_ctrl(2'b00);
    repeat (S4) @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk(frame_flag == 1, "R7 set wins over read", frame_flag, 1);

    // R6 unmasked write keeps pending flag
    write_ctrl(2'b00);
    chk(frame_flag == 1, "R6 unmasked write keeps flag", frame_flag, 1);
    // R6 masked write clears pending flag, nothing set afterwards
    write_ctrl(2'b01);
    chk(frame_flag == 0, "R6 mask clears flag", frame_flag, 0);
    flag_seen = 0;
    repeat (2 * (S4 + 1) + 5) begin @(negedge clk); if (frame_flag) flag_seen++; end
    chk(flag_seen == 0, "R6 no flag while masked", flag_seen, 0);

    // R10 idle enable: no ticks
    en_mode = 2;
    @(negedge clk);
    n = 0;
    repeat (3 * S5) begin @(negedge clk); if (quarter_tick) n++; end
    chk(n == 0, "R10 no ticks while enable low", n, 0);

    // slow enable run in four-step mode
    en_mode = 1;
    write_ctrl(2'b00);
    repeat (3 * (S4 + 1) + 7) @(negedge clk);
    read_stat();
    en_mode = 0;

    // R9 five-step write ticks at once, R3/R5 period and no flag
    write_ctrl(2'b10);
    chk(quarter_tick == 1 && half_tick == 1, "R9 immediate ticks", quarter_tick, 1);
    hcnt = 0; n = 0; flag_seen = 0;
    while (hcnt < 4 && n < 1000) begin
      @(negedge clk); n++;
      if (frame_flag) flag_seen++;
      if (half_tick) begin htimes[hcnt] = n; hcnt++; end
    end
    chk(htimes[2] - htimes[0] == S5 + 1, "R3 five-step period", htimes[2] - htimes[0], S5 + 1);
    chk(htimes[0] == S2 + 1, "R5 half at step 2", htimes[0], S2 + 1);
    chk(htimes[1] == S5 + 1, "R5 half at step 5", htimes[1], S5 + 1);
    chk(flag_seen == 0, "R5 no flag in five-step", flag_seen, 0);

    // R3 four-step period via flag spacing
    write_ctrl(2'b00);
    repeat (S4 + 1) @(negedge clk);
    read_stat();
    n = 1;
    while (!frame_flag && n < 1000) begin @(negedge clk); n++; end
    chk(n == S4 + 1, "R3 four-step period", n, S4 + 1);

    // R9 five-step with mask mid-frame, flag cleared too
    repeat (7) @(negedge clk);
    write_ctrl(2'b11);
    chk(quarter_tick == 1 && half_tick == 1, "R9 ticks on masked five write", half_tick, 1);
    chk(frame_flag == 0, "R6 masked five write clears", frame_flag, 0);
    repeat (2 * (S5 + 1)) @(negedge clk);

    // R1 reset again mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(frame_flag == 0 && quarter_tick == 0, "R1 reset clears state", frame_flag, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!quarter_tick && n < 1000);
    chk(n == S1 + 1, "R1 count zero after reset", n, S1 + 1);

    summary();
    $finish;
  end

endmodule